// File: doc/BRIEF.md
# Write-Only Serial Command Receiver for a Coil Current Driver

This block is a two-wire serial bus target that only accepts writes. It samples the bus clock and data lines with the system clock and detects the start and stop conditions. It then takes in a fixed frame of four bytes: a header byte that holds the 7-bit device address and the direction bit, followed by three payload bytes. It acknowledges every byte it accepts by pulling the data line low during the ninth bus clock.

The payload sets three controls of a coil current driver: a power-down flag, a 10-bit drive-current code, and a slope setting. The slope setting is a 3-bit step-size field and a 3-bit step-time field. None of these outputs moves until the whole payload has been received. Then all of them change in the same system-clock cycle, marked by a one-cycle commit strobe.

An active-low enable input clears the block completely: every output goes to zero and no bus traffic is acknowledged while the enable is low.

Top module: `vcm_cmd_rx`

## Requirements
- R1: A frame is accepted when its header byte is 0x66, which is the device address 0110011 (sent most significant bit first) followed by a write bit of 0. Each accepted byte is acknowledged by driving `sdaPullLow` high during the ninth bus clock. The acknowledge is released at the falling edge of that ninth clock.
- R2: A header byte carrying any other address, or carrying the read bit 1, is not acknowledged. The bytes after such a header are not acknowledged either. No output changes and no commit strobe fires.
- R3: The payload fields map to the outputs as follows. Payload byte 1: bit 7 is `powerDown`, bits 5..0 are `currentCode[9:4]`. Payload byte 2: bits 7..4 are `currentCode[3:0]`. Payload byte 3: bits 7..5 are `stepSize`, bits 4..2 are `stepTime`. Byte 1 bit 6, byte 2 bits 3..0 and byte 3 bits 1..0 have no effect. Bytes are sent most significant bit first, and a bit is sampled on the rising edge of the bus clock.
- R4: All outputs keep their previous values until the ninth-clock falling edge of the third payload byte. At that point they all update in the same cycle, and `commitPulse` is high for exactly that one cycle.
- R5: A start or stop condition that arrives before that commit point abandons the frame, with no commit and no output change. A repeated start begins a new frame.
- R6: Any byte sent after the third payload byte, up to the next start condition, is not acknowledged and changes nothing.
- R7: While `chipEn` is low, all outputs are 0, `sdaPullLow` is 0 and the bus is ignored. The clearing takes effect at once, without waiting for a clock edge.
- R8: Counting the system clock edge at which a falling edge on `scl` is first sampled as the first edge, the commit (R4) and the release or assertion of the acknowledge appear after the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the bus bit rate |
| chipEn | input | 1 | Active-low clear; high for normal operation |
| scl | input | 1 | Bus clock line |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaPullLow | output | 1 | High to pull the data line low (acknowledge) |
| powerDown | output | 1 | Committed power-down flag |
| currentCode | output | 10 | Committed drive-current code |
| stepSize | output | 3 | Committed slope step-size field |
| stepTime | output | 3 | Committed slope step-time field |
| commitPulse | output | 1 | One-cycle strobe marking a register update |

## Verification
Each bus line reaches the decode logic through two synchronizer flops. The decode then registers its result one edge later, so the commit, the output update and the change of the acknowledge are due after the third system-clock rising edge that follows an edge on `scl`. The bench drives the bus lines just after a falling clock edge. At the ninth falling bus clock of the last payload byte it counts falling clock edges: after the second it checks that the old values and the acknowledge still hold, after the third it checks the new values together with the strobe, and after the fourth it checks that the strobe has dropped. All other checks, such as acknowledge sampling and register values, are made tens of cycles after the bus edge that triggers them, well clear of that three-cycle window.

// File: rtl/vcm_cmd_pkg.sv
package vcm_cmd_pkg;
  localparam int BYTE_W    = 8;
  localparam int CODE_W    = 10;
  localparam int CODE_HI_W = 6;
  localparam int CODE_LO_W = CODE_W - CODE_HI_W;
  localparam int SLOPE_W   = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BITS,
    ST_ACK,
    ST_SKIP
  } rxState_t;

  typedef struct packed {
    logic shiftBit;
    logic keepB1;
    logic keepB2;
    logic commit;
  } rxStrobe_t;
endpackage

// File: rtl/vcm_cmd_ctrl.sv
module vcm_cmd_ctrl
  import vcm_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_BYTES = 4
) (
  input  logic      clk,
  input  logic      chipEn,
  input  logic      scl,
  input  logic      sdaIn,
  input  logic      addrHit,
  output logic      sdaSync,
  output rxStrobe_t strobe,
  output logic      ackDrive
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam int IDX_W = $clog2(FRAME_BYTES);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(BYTE_W);
  localparam logic [IDX_W-1:0] LAST_BYTE = IDX_W'(FRAME_BYTES - 1);

  logic [SYNC_STAGES-1:0] sclChain, sdaChain;
  logic sclPrev, sdaPrev, sclSync;
  logic sclRise, sclFall, startDet, stopDet;
  rxState_t state;
  logic [CNT_W-1:0] bitCnt;
  logic [IDX_W-1:0] byteIdx;

  // idle bus is high on both lines, so the chain resets to ones
  always_ff @(posedge clk or negedge chipEn) begin
    if (!chipEn) begin
      sclChain <= '1;
      sdaChain <= '1;
      sclPrev  <= 1'b1;
      sdaPrev  <= 1'b1;
    end else begin
      sclChain <= {sclChain[SYNC_STAGES-2:0], scl};
      sdaChain <= {sdaChain[SYNC_STAGES-2:0], sdaIn};
      sclPrev  <= sclSync;
      sdaPrev  <= sdaSync;
    end
  end

  assign sclSync  = sclChain[SYNC_STAGES-1];
  assign sdaSync  = sdaChain[SYNC_STAGES-1];
  assign sclRise  = sclSync & ~sclPrev;
  assign sclFall  = ~sclSync & sclPrev;
  assign startDet = sclSync & sclPrev & sdaPrev & ~sdaSync;
  assign stopDet  = sclSync & sclPrev & ~sdaPrev & sdaSync;

  always_ff @(posedge clk or negedge chipEn) begin
    if (!chipEn) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      byteIdx  <= '0;
      ackDrive <= 1'b0;
    end else if (startDet) begin
      state    <= ST_BITS;
      bitCnt   <= '0;
      byteIdx  <= '0;
      ackDrive <= 1'b0;
    end else if (stopDet) begin
      state    <= ST_IDLE;
      ackDrive <= 1'b0;
    end else begin
      unique case (state)
        ST_BITS: begin
          if (sclRise && bitCnt < LAST_BIT) bitCnt <= bitCnt + 1'b1;
          if (sclFall && bitCnt == LAST_BIT) begin
            if (byteIdx == '0 && !addrHit) begin
              state <= ST_SKIP;
            end else begin
              state    <= ST_ACK;
              ackDrive <= 1'b1;
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            ackDrive <= 1'b0;
            bitCnt   <= '0;
            if (byteIdx == LAST_BYTE) begin
              state <= ST_SKIP;
            end else begin
              state   <= ST_BITS;
              byteIdx <= byteIdx + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.shiftBit = (state == ST_BITS) && sclRise && (bitCnt < LAST_BIT);
    strobe.keepB1   = (state == ST_BITS) && sclFall && (bitCnt == LAST_BIT)
                      && (byteIdx == IDX_W'(1));
    strobe.keepB2   = (state == ST_BITS) && sclFall && (bitCnt == LAST_BIT)
                      && (byteIdx == IDX_W'(2));
    strobe.commit   = (state == ST_ACK) && sclFall && (byteIdx == LAST_BYTE);
  end

  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!chipEn)
    (ackDrive && sclFall && !startDet && !stopDet) |=> !ackDrive); // R1
  AST_ACK_ONLY_ON_MATCH: assert property (@(posedge clk) disable iff (!chipEn)
    ($rose(ackDrive) && byteIdx == '0) |-> addrHit); // R2
  AST_EVENT_DROPS_ACK: assert property (@(posedge clk) disable iff (!chipEn)
    (startDet || stopDet) |=> !ackDrive); // R5
endmodule

// File: rtl/vcm_cmd_data.sv
module vcm_cmd_data
  import vcm_cmd_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h33
) (
  input  logic               clk,
  input  logic               chipEn,
  input  logic               sdaSync,
  input  rxStrobe_t          strobe,
  output logic               addrHit,
  output logic               powerDown,
  output logic [CODE_W-1:0]  currentCode,
  output logic [SLOPE_W-1:0] stepSize,
  output logic [SLOPE_W-1:0] stepTime,
  output logic               commitPulse
);
  localparam logic [BYTE_W-1:0] WRITE_HEADER = {DEV_ADDR, 1'b0};

  logic [BYTE_W-1:0]    shiftReg;
  logic                 keepPd;
  logic [CODE_HI_W-1:0] keepCodeHi;
  logic [CODE_LO_W-1:0] keepCodeLo;

  assign addrHit = (shiftReg == WRITE_HEADER);

  always_ff @(posedge clk or negedge chipEn) begin
    if (!chipEn) begin
      shiftReg   <= '0;
      keepPd     <= 1'b0;
      keepCodeHi <= '0;
      keepCodeLo <= '0;
    end else begin
      if (strobe.shiftBit) shiftReg <= {shiftReg[BYTE_W-2:0], sdaSync};
      if (strobe.keepB1) begin
        keepPd     <= shiftReg[BYTE_W-1];
        keepCodeHi <= shiftReg[CODE_HI_W-1:0];
      end
      if (strobe.keepB2) keepCodeLo <= shiftReg[BYTE_W-1 -: CODE_LO_W];
    end
  end

  // committed copy: all fields land on the same edge
  always_ff @(posedge clk or negedge chipEn) begin
    if (!chipEn) begin
      powerDown   <= 1'b0;
      currentCode <= '0;
      stepSize    <= '0;
      stepTime    <= '0;
      commitPulse <= 1'b0;
    end else begin
      commitPulse <= strobe.commit;
      if (strobe.commit) begin
        powerDown   <= keepPd;
        currentCode <= {keepCodeHi, keepCodeLo};
        stepSize    <= shiftReg[BYTE_W-1 -: SLOPE_W];
        stepTime    <= shiftReg[BYTE_W-1-SLOPE_W -: SLOPE_W];
      end
    end
  end

  AST_ATOMIC_UPDATE: assert property (@(posedge clk) disable iff (!chipEn)
    !$stable({powerDown, currentCode, stepSize, stepTime}) |-> commitPulse); // R4
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!chipEn)
    commitPulse |=> !commitPulse); // R4
  AST_CLEAR_ON_ENABLE: assert property (@(posedge clk)
    $rose(chipEn) |-> (currentCode == '0 && !powerDown && stepSize == '0
                       && stepTime == '0 && !commitPulse)); // R7
endmodule

// File: rtl/vcm_cmd_rx.sv
module vcm_cmd_rx
  import vcm_cmd_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h33,
  parameter int         SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         chipEn,
  input  logic         scl,
  input  logic         sdaIn,
  output logic         sdaPullLow,
  output logic         powerDown,
  output logic [9:0]   currentCode,
  output logic [2:0]   stepSize,
  output logic [2:0]   stepTime,
  output logic         commitPulse
);
  localparam int FRAME_BYTES = 4;

  rxStrobe_t strobe;
  logic sdaSync, addrHit;

  vcm_cmd_ctrl #(.SYNC_STAGES(SYNC_STAGES), .FRAME_BYTES(FRAME_BYTES)) i_ctrl (
    .clk(clk), .chipEn(chipEn), .scl(scl), .sdaIn(sdaIn), .addrHit(addrHit),
    .sdaSync(sdaSync), .strobe(strobe), .ackDrive(sdaPullLow)
  );

  vcm_cmd_data #(.DEV_ADDR(DEV_ADDR)) i_data (
    .clk(clk), .chipEn(chipEn), .sdaSync(sdaSync), .strobe(strobe),
    .addrHit(addrHit), .powerDown(powerDown), .currentCode(currentCode),
    .stepSize(stepSize), .stepTime(stepTime), .commitPulse(commitPulse)
  );
endmodule

// File: tb/test_vcm_cmd_rx.sv
module test_vcm_cmd_rx;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic chipEn = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic sdaPullLow, powerDown, commitPulse;
  logic [9:0] currentCode;
  logic [2:0] stepSize, stepTime;
  wire sdaLine = sdaM & ~sdaPullLow;

  int checks = 0, errors = 0, pulses = 0, expPulses = 0;
  bit done = 0;
  int mPd = 0, mCode = 0, mSs = 0, mSt = 0;
  int nPd = 0, nCode = 0, nSs = 0, nSt = 0;

  always #4 clk = ~clk;

  vcm_cmd_rx i_vcm_cmd_rx (
    .clk(clk), .chipEn(chipEn), .scl(scl), .sdaIn(sdaLine),
    .sdaPullLow(sdaPullLow), .powerDown(powerDown), .currentCode(currentCode),
    .stepSize(stepSize), .stepTime(stepTime), .commitPulse(commitPulse)
  );

  always @(negedge clk) if (commitPulse) pulses++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic regsCheck(input string req);
    chk({req, " powerDown"}, int'(powerDown), mPd);
    chk({req, " currentCode"}, int'(currentCode), mCode);
    chk({req, " stepSize"}, int'(stepSize), mSs);
    chk({req, " stepTime"}, int'(stepTime), mSt);
    chk({req, " commit count"}, pulses, expPulses);
  endtask

  task automatic busStart();
    sdaM = 1; scl = 1; qwait(); sdaM = 0; qwait(); scl = 0; qwait();
  endtask

  task automatic busStop();
    sdaM = 0; qwait(); scl = 1; qwait(); sdaM = 1; qwait(); qwait();
  endtask

  // timeIt: check the three-edge commit latency on the ninth falling clock
  task automatic sendByte(input logic [7:0] b, input bit timeIt, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; qwait(); scl = 1; qwait(); qwait(); scl = 0; qwait();
    end
    sdaM = 1; qwait(); scl = 1; qwait();
    acked = !sdaLine; qwait();
    scl = 0;
    if (timeIt) begin
      @(negedge clk); @(negedge clk);
      chk("R8 ack held after two edges", int'(sdaPullLow), 1);
      chk("R8 no commit after two edges", int'(commitPulse), 0);
      chk("R4 old code before commit", int'(currentCode), mCode);
      @(negedge clk);
      chk("R8 commit after third edge", int'(commitPulse), 1);
      chk("R8 ack released after third edge", int'(sdaPullLow), 0);
      chk("R4 code at commit", int'(currentCode), nCode);
      chk("R4 powerDown at commit", int'(powerDown), nPd);
      chk("R4 stepSize at commit", int'(stepSize), nSs);
      chk("R4 stepTime at commit", int'(stepTime), nSt);
      @(negedge clk);
      chk("R4 single-cycle strobe", int'(commitPulse), 0);
    end
    qwait();
    chk("R1 ack released after ninth clock", int'(sdaPullLow), 0);
  endtask

  // sends a full four-byte frame; expectAck=1 means it should commit
  task automatic frame(input logic [7:0] h, input logic [7:0] b1, input logic [7:0] b2,
                       input logic [7:0] b3, input bit expectAck, input string req);
    bit a;
    nPd = int'(b1[7]);
    nCode = (int'(b1) % 64) * 16 + int'(b2) / 16;
    nSs = int'(b3) / 32;
    nSt = (int'(b3) / 4) % 8;
    busStart();
    sendByte(h, 0, a);  chk({req, " header ack"}, int'(a), int'(expectAck));
    sendByte(b1, 0, a); chk({req, " byte1 ack"}, int'(a), int'(expectAck));
    sendByte(b2, 0, a); chk({req, " byte2 ack"}, int'(a), int'(expectAck));
    sendByte(b3, expectAck, a); chk({req, " byte3 ack"}, int'(a), int'(expectAck));
    busStop();
    if (expectAck) begin
      mPd = nPd; mCode = nCode; mSs = nSs; mSt = nSt; expPulses++;
    end
    regsCheck(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    bit a;
    repeat (5) @(negedge clk);
    regsCheck("R7 held in clear");
    chk("R7 no pull in clear", int'(sdaPullLow), 0);
    chipEn = 1;
    repeat (5) @(negedge clk);
    regsCheck("R7 reset state");

    // R3: all-ones fields, unused bits zero
    frame(8'h66, 8'hBF, 8'hF0, 8'hFC, 1, "R3 max fields");

    // R3/R1 sweep with junk in the unused bits
    for (int i = 0; i < 40; i++) begin
      int code, ss, st;
      logic [7:0] b1, b2, b3;
      code = (i * 211 + 5) % 1024;
      ss = i % 8;
      st = (i * 3 + 1) % 8;
      b1 = 8'((i % 2) * 128 + ((i / 2) % 2) * 64 + code / 16);
      b2 = 8'((code % 16) * 16 + (i * 7) % 16);
      b3 = 8'(ss * 32 + st * 4 + i % 4);
      frame(8'h66, b1, b2, b3, 1, "R3 sweep");
    end

    // R2: wrong address, then read bit
    frame(8'h68, 8'h3F, 8'hF0, 8'hFC, 0, "R2 wrong address");
    frame(8'h67, 8'h3F, 8'hF0, 8'hFC, 0, "R2 read bit");

    // R5: stop after two payload bytes
    busStart();
    sendByte(8'h66, 0, a); sendByte(8'h12, 0, a); sendByte(8'h34, 0, a);
    busStop();
    regsCheck("R5 stop abort");

    // R5: repeated start mid-frame, then a full new frame
    busStart();
    sendByte(8'h66, 0, a); sendByte(8'h2A, 0, a); sendByte(8'h50, 0, a);
    regsCheck("R5 restart abort");
    frame(8'h66, 8'h15, 8'hA0, 8'h48, 1, "R5 frame after restart");

    // R6: a fifth byte is not acknowledged and changes nothing
    nPd = 0; nCode = 9 * 16 + 6; nSs = 5; nSt = 2;
    busStart();
    sendByte(8'h66, 0, a); sendByte(8'h09, 0, a); sendByte(8'h60, 0, a);
    sendByte(8'hA8, 1, a);
    mPd = nPd; mCode = nCode; mSs = nSs; mSt = nSt; expPulses++;
    sendByte(8'hFF, 0, a);
    chk("R6 extra byte nack", int'(a), 0);
    busStop();
    regsCheck("R6 extra byte");

    // R7: clear while active, ignore bus, then recover
    @(negedge clk);
    chipEn = 0;
    @(negedge clk);
    mPd = 0; mCode = 0; mSs = 0; mSt = 0;
    regsCheck("R7 immediate clear");
    frame(8'h66, 8'hBF, 8'hF0, 8'hFC, 0, "R7 bus ignored in clear");
    chipEn = 1;
    repeat (5) @(negedge clk);
    regsCheck("R7 after re-enable");
    frame(8'h66, 8'h01, 8'h10, 8'h24, 1, "R1 frame after re-enable");

    report();
  end
endmodule